// File: doc/BRIEF.md
# Banked Data Address Resolver

This block turns the data operand of an 8-bit microcontroller instruction into a 12-bit effective data memory address. It takes the 8-bit file operand, the access-select bit, a 4-bit bank register, a 12-bit pointer register and a configuration bit that enables the extended addressing mode. From these it forms one of three kinds of address: a direct access-bank address, a banked address, or a pointer-relative address made from a literal offset.

With the extension disabled, the operand always names a fixed location. With the extension enabled and the access bit low, operands up to 5Fh become unsigned offsets from the pointer. Operands from 60h upward keep their fixed access-bank meaning. The result is registered and appears one clock after the inputs, together with a flag that shows when pointer-relative addressing was used.

Top module: `bdar_top`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released, the address output is 000h and the indexed flag is 0.
- R2: With the extension bit 0, the access bit 0 and an operand of 00h to 5Fh, the address is 000h plus the operand (000h to 05Fh).
- R3: With the access bit 0 and an operand of 60h to FFh, the address is F00h plus the operand (F60h to FFFh), whatever the value of the extension bit.
- R4: With the access bit 1, the address is the bank value in bits 11:8 and the operand in bits 7:0, and the extension bit has no effect.
- R5: With the extension bit 1, the access bit 0 and an operand of 00h to 5Fh, the address is the pointer plus the operand, with the operand treated as unsigned.
- R6: The pointer-plus-offset sum wraps modulo 4096. For example, pointer FF0h plus offset 20h gives 010h.
- R7: The indexed flag is 1 exactly when the address came from the pointer-relative rule of R5.
- R8: The address and the flag show the inputs that were present at the previous rising clock edge. The latency is one cycle.
- R9: With the pointer at 000h, an indexed access to offset k gives the same address as an unextended access-bank access to k, for k from 00h to 5Fh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_i | input | 8 | File operand from the instruction |
| acc_sel_i | input | 1 | 0 selects the access bank, 1 selects the bank register |
| bank_i | input | 4 | Bank select register |
| ptr_i | input | 12 | Pointer register used as the indexed base |
| ext_en_i | input | 1 | Extended addressing enable (configuration bit) |
| addr_o | output | 12 | Registered effective data address |
| idx_o | output | 1 | Registered flag: the address was pointer-relative |

## Verification
Directed operands are placed on both sides of the 5Fh/60h split, once with the extension enabled and once with it disabled. This separates the offset rule from the fixed access-bank rule at exactly the boundary value. Banked cases are run with the extension bit set, to show that the access bit takes priority. A pointer near the top of the address space shows that the sum wraps correctly. A zero pointer is compared with unextended accesses to show that the two give the same addresses. A long run of random inputs, checked every cycle against a behavioural model, covers how the modes interleave from one cycle to the next and confirms the one-cycle latency.

// File: rtl/bdar_pkg.sv
package bdar_pkg;
   typedef enum logic [1:0] {
      AM_ACCESS  = 2'd0,
      AM_BANKED  = 2'd1,
      AM_INDEXED = 2'd2
   } amode_t;
endpackage

// File: rtl/bdar_mode_sel.sv
module bdar_mode_sel
   import bdar_pkg::*;
#(
   parameter int OPND_W  = 8,
   parameter int SPLIT_PT = 96
) (
   input  logic [OPND_W-1:0] opnd_i,
   input  logic              acc_sel_i,
   input  logic              ext_en_i,
   output amode_t            mode_o,
   output logic              low_half_o
);
   localparam logic [OPND_W-1:0] SPLIT_V = OPND_W'(SPLIT_PT);

   always_comb begin
      low_half_o = (opnd_i < SPLIT_V);
      if (acc_sel_i)                    mode_o = AM_BANKED;
      else if (ext_en_i && low_half_o)  mode_o = AM_INDEXED;
      else                              mode_o = AM_ACCESS;
   end
endmodule

// File: rtl/bdar_addr_calc.sv
module bdar_addr_calc
   import bdar_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int OPND_W = 8,
   parameter int BANK_W = 4
) (
   input  amode_t            mode_i,
   input  logic              low_half_i,
   input  logic [OPND_W-1:0] opnd_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic [ADDR_W-1:0] ptr_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int HI_W = ADDR_W - OPND_W;

   logic [ADDR_W-1:0] opnd_zx;
   logic [ADDR_W-1:0] idx_sum;
   logic [ADDR_W-1:0] acc_addr;
   logic [ADDR_W-1:0] bank_addr;

   assign opnd_zx = {{HI_W{1'b0}}, opnd_i};
   assign idx_sum = ptr_i + opnd_zx;

   always_comb begin
      acc_addr  = {{HI_W{~low_half_i}}, opnd_i};
      bank_addr = {{(HI_W-BANK_W+1){1'b0}}, bank_i, opnd_i} [ADDR_W-1:0];
      case (mode_i)
         AM_BANKED:  addr_o = bank_addr;
         AM_INDEXED: addr_o = idx_sum;
         default:    addr_o = acc_addr;
      endcase
   end
endmodule

// File: rtl/bdar_top.sv
module bdar_top
   import bdar_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int OPND_W   = 8,
   parameter int BANK_W   = 4,
   parameter int SPLIT_PT = 96,
   parameter bit OUT_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [7:0]        opnd_i,
   input  logic              acc_sel_i,
   input  logic [3:0]        bank_i,
   input  logic [11:0]       ptr_i,
   input  logic              ext_en_i,
   output logic [11:0]       addr_o,
   output logic              idx_o
);
   localparam int HI_W = ADDR_W - OPND_W;

   generate
      if (ADDR_W != 12 || OPND_W != 8 || BANK_W != 4) begin : g_bad_port_w
         $error("bdar_top: port widths are fixed at 12/8/4");
      end
      if (HI_W < BANK_W) begin : g_bad_hi
         $error("bdar_top: bank field does not fit above operand");
      end
      if (SPLIT_PT < 1 || SPLIT_PT >= (1 << OPND_W)) begin : g_bad_split
         $error("bdar_top: split point out of operand range");
      end
   endgenerate

   amode_t            mode;
   logic              low_half;
   logic [ADDR_W-1:0] addr_nx;

   bdar_mode_sel #(.OPND_W(OPND_W), .SPLIT_PT(SPLIT_PT)) u_mode (
      .opnd_i     (opnd_i),
      .acc_sel_i  (acc_sel_i),
      .ext_en_i   (ext_en_i),
      .mode_o     (mode),
      .low_half_o (low_half)
   );

   bdar_addr_calc #(.ADDR_W(ADDR_W), .OPND_W(OPND_W), .BANK_W(BANK_W)) u_calc (
      .mode_i     (mode),
      .low_half_i (low_half),
      .opnd_i     (opnd_i),
      .bank_i     (bank_i),
      .ptr_i      (ptr_i),
      .addr_o     (addr_nx)
   );

   generate
      if (OUT_REG) begin : g_reg
         logic [ADDR_W-1:0] addr_q;
         logic              idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q <= '0;
               idx_q  <= 1'b0;
            end else begin
               addr_q <= addr_nx;
               idx_q  <= (mode == AM_INDEXED);
            end
         end
         assign addr_o = addr_q;
         assign idx_o  = idx_q;

         AST_BANKED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
            acc_sel_i |=> (addr_o == {$past(bank_i), $past(opnd_i)}) && !idx_o); // R4
         AST_HIGH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
            (!acc_sel_i && opnd_i >= 8'h60) |=> (addr_o[11:8] == 4'hF) && !idx_o); // R3
         AST_LOW_LITERAL: assert property (@(posedge clk) disable iff (!rst_n)
            (!acc_sel_i && !ext_en_i && opnd_i < 8'h60) |=> (addr_o == {4'h0, $past(opnd_i)})); // R2
         AST_IDX_SUM: assert property (@(posedge clk) disable iff (!rst_n)
            (!acc_sel_i && ext_en_i && opnd_i < 8'h60) |=> idx_o && (addr_o == 12'($past(ptr_i) + {4'h0, $past(opnd_i)}))); // R5
         AST_IDX_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            idx_o |-> $past(ext_en_i) && !$past(acc_sel_i)); // R7
      end else begin : g_comb
         assign addr_o = addr_nx;
         assign idx_o  = (mode == AM_INDEXED);
      end
   endgenerate
endmodule

// File: tb/bdar_top_tb.sv
module bdar_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  opnd_i = 8'h3C;
   logic        acc_sel_i = 1'b0;
   logic [3:0]  bank_i = 4'h5;
   logic [11:0] ptr_i = 12'h123;
   logic        ext_en_i = 1'b1;
   logic [11:0] addr_o;
   logic        idx_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bdar_top u_dut (
      .clk(clk), .rst_n(rst_n), .opnd_i(opnd_i), .acc_sel_i(acc_sel_i),
      .bank_i(bank_i), .ptr_i(ptr_i), .ext_en_i(ext_en_i),
      .addr_o(addr_o), .idx_o(idx_o)
   );

   function automatic int model_addr(int op, int acc, int bk, int p, int ext);
      if (acc != 0)                 return bk * 256 + op;
      if (ext != 0 && op < 96)      return (p + op) % 4096;
      if (op < 96)                  return op;
      return 3840 + op;
   endfunction

   function automatic int model_idx(int op, int acc, int ext);
      return (acc == 0 && ext != 0 && op < 96) ? 1 : 0;
   endfunction

   task automatic check(string tag, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s: got %0h expected %0h", tag, got, exp);
      end
   endtask

   // drive at negedge, sample result one negedge later (one register)
   task automatic apply(string tag, int op, int acc, int bk, int p, int ext);
      int ea, ei;
      opnd_i = 8'(op); acc_sel_i = 1'(acc); bank_i = 4'(bk);
      ptr_i = 12'(p); ext_en_i = 1'(ext);
      ea = model_addr(op, acc, bk, p, ext);
      ei = model_idx(op, acc, ext);
      @(negedge clk);
      check({tag, " addr"}, int'(addr_o), ea);
      check({tag, " idx"},  int'(idx_o),  ei);
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      check("R1 reset addr", int'(addr_o), 0);
      check("R1 reset idx",  int'(idx_o),  0);
      rst_n = 1'b1;
      // R2 literal low access bank, extension off
      apply("R2 op00", 8'h00, 0, 4'h7, 12'hA00, 0);
      apply("R2 op5F", 8'h5F, 0, 4'h7, 12'hA00, 0);
      // R3 high access bank with and without extension
      apply("R3 op60 ext", 8'h60, 0, 4'h2, 12'hA00, 1);
      apply("R3 opFF noext", 8'hFF, 0, 4'h2, 12'hA00, 0);
      // R5 pointer-relative, boundary 5Fh
      apply("R5 A00+2C", 8'h2C, 0, 4'h0, 12'hA00, 1);
      apply("R5 A00+0A", 8'h0A, 0, 4'h0, 12'hA00, 1);
      apply("R5 op5F", 8'h5F, 0, 4'h0, 12'h400, 1);
      // R4 banked ignores extension
      apply("R4 bank ext", 8'h2C, 1, 4'h9, 12'hA00, 1);
      apply("R4 bank noext", 8'hE1, 1, 4'hF, 12'hA00, 0);
      // R6 wrap
      apply("R6 FF0+20", 8'h20, 0, 4'h0, 12'hFF0, 1);
      apply("R6 FFF+5F", 8'h5F, 0, 4'h0, 12'hFFF, 1);
      // R9 zero pointer equals unextended
      for (int k = 0; k < 96; k += 19) begin
         apply("R9 zero ptr", k, 0, 4'h3, 12'h000, 1);
         check("R9 match unext", int'(addr_o), model_addr(k, 0, 3, 0, 0));
      end
      // R7 R8 random stream, checked every cycle
      for (int i = 0; i < 400; i++) begin
         apply("R8 R7 random", $urandom_range(0, 255), $urandom_range(0, 1),
               $urandom_range(0, 15), $urandom_range(0, 4095), $urandom_range(0, 1));
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule